// File: doc/BRIEF.md
# Masked Interrupt Status Register Bank

This block gathers four interrupt events into sticky status bits and folds them into a single summary request line. The events are a change of state on a user pin, a run-length error, a transmit FIFO overflow and a transmit FIFO underflow. Software reaches two registers through an indexed configuration bus. The status register holds the sticky event bits, and software clears a bit by writing 1 to it. The unmask register chooses which status bits may drive the summary output.

The user pin is asynchronous. It passes through a synchronizer chain, and then an edge detector turns it into an event. A 2-bit select input sets which transitions count, and one setting switches the source off. The summary output is high whenever any status bit is set while its unmask bit is also set. A higher-level interrupt controller uses it as one "more interrupts" flag.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, the status register at index 0x0B reads 0x04, with only the run-length error bit set. The unmask register at index 0x0C reads 0x00, and `more_irq` is 0.
- R2: A high level on an event input at a rising clock edge sets its status bit, and the bit stays set after the event goes low. The bit positions are: 3 for the user-pin event, 2 for the run-length error, 1 for transmit FIFO overflow and 0 for transmit FIFO underflow.
- R3: A write to index 0x0B clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R4: When an event and a clear by write hit the same status bit in the same cycle, the bit stays set.
- R5: A write to index 0x0C loads write-data bits 3:0 into the unmask register, and a read of 0x0C returns them.
- R6: `more_irq` is 1 exactly when some status bit and its unmask bit are both 1. It follows a register change on the next clock edge.
- R7: Read-data bits 7:4 always read 0, and writes to them have no effect. A read of any index other than 0x0B or 0x0C returns 0x00.
- R8: With `pin_sel` = 00, no transition on `pin_in` sets status bit 3.
- R9: With `pin_sel` = 01, only a low-to-high transition on `pin_in` sets status bit 3.
- R10: With `pin_sel` = 10, only a high-to-low transition on `pin_in` sets status bit 3.
- R11: With `pin_sel` = 11, a transition in either direction on `pin_in` sets status bit 3.
- R12: With the default two-stage synchronizer, a `pin_in` change is not visible in the status after two rising clock edges. Status bit 3 reads 1 after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Configuration register index |
| cfg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| cfg_wdata | input | 8 | Write data |
| cfg_rd_data | output | 8 | Read data for `cfg_addr` (combinational) |
| pin_in | input | 1 | Asynchronous user pin |
| pin_sel | input | 2 | User-pin edge select: 00 off, 01 rising, 10 falling, 11 both |
| ev_runlen | input | 1 | Run-length error event |
| ev_txovf | input | 1 | Transmit FIFO overflow event |
| ev_txunf | input | 1 | Transmit FIFO underflow event |
| more_irq | output | 1 | Summary of unmasked pending status |

## Verification
The bench drives an event and a write-1 clear into the same bit in the same cycle. A design that gave the clear priority would lose that interrupt and read the bit as 0. It writes zeros, and writes to the reserved upper bits, to catch a design that clears on any write or stores the reserved bits. It steps the user pin through every select setting and samples after the second and after the third clock edge. This exposes a missing synchronizer stage, a swapped rising/falling decode, or a disabled setting that still reports edges. Finally it checks that the run-length bit comes out of reset set, and that the summary output stays low while every unmask bit is 0.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
   localparam int unsigned IRQ_NSRC = 4;
   localparam int unsigned IRQ_BIT_TXUNF = 0;
   localparam int unsigned IRQ_BIT_TXOVF = 1;
   localparam int unsigned IRQ_BIT_RUNLEN = 2;
   localparam int unsigned IRQ_BIT_PIN = 3;
   localparam logic [IRQ_NSRC-1:0] IRQ_STAT_RST = 4'b0100;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
   import irq_bank_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_in,
   input  logic [1:0] sel,
   output logic       evt
);
   localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_pin_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;
   logic               cur_lvl;
   logic               old_lvl;
   logic               rise;
   logic               fall;
   edge_sel_e          mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[CHAIN_W-2:0], pin_in};
      end
   end

   assign cur_lvl = chain_q[SYNC_STAGES-1];
   assign old_lvl = chain_q[SYNC_STAGES];
   assign rise    = cur_lvl & ~old_lvl;
   assign fall    = ~cur_lvl & old_lvl;
   assign mode    = edge_sel_e'(sel);

   always_comb begin
      unique case (mode)
         EDGE_OFF:  evt = 1'b0;
         EDGE_RISE: evt = rise;
         EDGE_FALL: evt = fall;
         EDGE_BOTH: evt = rise | fall;
         default:   evt = 1'b0;
      endcase
   end
endmodule

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
   parameter int unsigned NBITS = 4,
   parameter logic [NBITS-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_i,
   input  logic [NBITS-1:0] clr_i,
   output logic [NBITS-1:0] q
);
   generate
      for (genvar b = 0; b < NBITS; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q[b] <= RST_VAL[b];
            end else if (set_i[b]) begin
               q[b] <= 1'b1;
            end else if (clr_i[b]) begin
               q[b] <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned NBITS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [NBITS-1:0] wdata,
   output logic [NBITS-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= wdata;
      end
   end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
   import irq_bank_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter logic [7:0]  STAT_INDEX  = 8'h0B,
   parameter logic [7:0]  MASK_INDEX  = 8'h0C,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rd_data,
   input  logic              pin_in,
   input  logic [1:0]        pin_sel,
   input  logic              ev_runlen,
   input  logic              ev_txovf,
   input  logic              ev_txunf,
   output logic              more_irq
);
   localparam int unsigned NSRC = IRQ_NSRC;

   generate
      if (DATA_W < NSRC) begin : g_bad_width
         $error("irq_status_bank: DATA_W narrower than the source count");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("irq_status_bank: ADDR_W too small for the register indices");
      end
   endgenerate

   logic            hit_stat;
   logic            hit_mask;
   logic            pin_evt;
   logic [NSRC-1:0] set_vec;
   logic [NSRC-1:0] clr_vec;
   logic [NSRC-1:0] stat_q;
   logic [NSRC-1:0] mask_q;
   logic [NSRC-1:0] wr_low;

   assign hit_stat = (cfg_addr == ADDR_W'(STAT_INDEX));
   assign hit_mask = (cfg_addr == ADDR_W'(MASK_INDEX));
   assign wr_low   = cfg_wdata[NSRC-1:0];

   irq_pin_edge #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .sel    (pin_sel),
      .evt    (pin_evt)
   );

   always_comb begin
      set_vec                 = '0;
      set_vec[IRQ_BIT_PIN]    = pin_evt;
      set_vec[IRQ_BIT_RUNLEN] = ev_runlen;
      set_vec[IRQ_BIT_TXOVF]  = ev_txovf;
      set_vec[IRQ_BIT_TXUNF]  = ev_txunf;
   end

   assign clr_vec = (cfg_wr && hit_stat) ? wr_low : '0;

   irq_w1c_bank #(
      .NBITS   (NSRC),
      .RST_VAL (IRQ_STAT_RST)
   ) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (clr_vec),
      .q     (stat_q)
   );

   irq_mask_reg #(
      .NBITS (NSRC)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_wr && hit_mask),
      .wdata (wr_low),
      .q     (mask_q)
   );

   assign more_irq = |(stat_q & mask_q);

   generate
      if (DATA_W > NSRC) begin : g_pad
         logic unused_hi;
         assign unused_hi = ^cfg_wdata[DATA_W-1:NSRC];
         always_comb begin
            if (hit_stat) begin
               cfg_rd_data = {{(DATA_W-NSRC){1'b0}}, stat_q};
            end else if (hit_mask) begin
               cfg_rd_data = {{(DATA_W-NSRC){1'b0}}, mask_q};
            end else begin
               cfg_rd_data = '0;
            end
         end
      end else begin : g_nopad
         always_comb begin
            if (hit_stat) begin
               cfg_rd_data = stat_q;
            end else if (hit_mask) begin
               cfg_rd_data = mask_q;
            end else begin
               cfg_rd_data = '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter logic [7:0]  STAT_INDEX = 8'h0B
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic              cfg_wr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic [DATA_W-1:0] cfg_rd_data,
   input logic [1:0]        pin_sel,
   input logic              ev_runlen,
   input logic              ev_txovf,
   input logic              ev_txunf,
   input logic              more_irq,
   input logic [3:0]        stat_q,
   input logic [3:0]        mask_q,
   input logic              pin_evt
);
   logic       wr_stat;
   logic [3:0] clr_req;
   logic [3:0] ev_vec;

   assign wr_stat = cfg_wr && (cfg_addr == ADDR_W'(STAT_INDEX));
   assign clr_req = wr_stat ? cfg_wdata[3:0] : 4'b0000;
   assign ev_vec  = {pin_evt, ev_runlen, ev_txovf, ev_txunf};

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ($past(stat_q) & ~$past(clr_req))) == ($past(stat_q) & ~$past(clr_req)))); // R2

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_runlen && clr_req[2]) |=> stat_q[2]); // R4

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[1] && !ev_txovf) |=> !stat_q[1]); // R3

   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_vec != 4'b0000) |=> ((stat_q & $past(ev_vec)) == $past(ev_vec))); // R2

   AST_SUMMARY_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      more_irq |-> (mask_q != 4'b0000)); // R6

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_data[DATA_W-1:4] == '0); // R7

   AST_PIN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel == 2'b00) |-> !pin_evt); // R8
endmodule

bind irq_status_bank irq_status_bank_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .STAT_INDEX (STAT_INDEX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_addr    (cfg_addr),
   .cfg_wr      (cfg_wr),
   .cfg_wdata   (cfg_wdata),
   .cfg_rd_data (cfg_rd_data),
   .pin_sel     (pin_sel),
   .ev_runlen   (ev_runlen),
   .ev_txovf    (ev_txovf),
   .ev_txunf    (ev_txunf),
   .more_irq    (more_irq),
   .stat_q      (stat_q),
   .mask_q      (mask_q),
   .pin_evt     (pin_evt)
);

// File: tb/tb_irq_status_bank.sv
module tb_irq_status_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_addr = 8'h00;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rd_data;
   logic       pin_in = 1'b0;
   logic [1:0] pin_sel = 2'b00;
   logic       ev_runlen = 1'b0;
   logic       ev_txovf = 1'b0;
   logic       ev_txunf = 1'b0;
   logic       more_irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [7:0] IDX_ST = 8'h0B;
   localparam logic [7:0] IDX_MK = 8'h0C;

   always #2 clk = ~clk;

   irq_status_bank dut (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rd_data(cfg_rd_data), .pin_in(pin_in),
      .pin_sel(pin_sel), .ev_runlen(ev_runlen), .ev_txovf(ev_txovf),
      .ev_txunf(ev_txunf), .more_irq(more_irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rd_data;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: ev_txunf = 1'b1;
         1: ev_txovf = 1'b1;
         default: ev_runlen = 1'b1;
      endcase
      @(negedge clk);
      ev_txunf = 1'b0; ev_txovf = 1'b0; ev_runlen = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(IDX_ST, v); check("R1 status reset", v, 8'h04);
      rd(IDX_MK, v); check("R1 unmask reset", v, 8'h00);
      check("R1 more_irq reset", {7'b0, more_irq}, 8'h00);
   endtask

   task automatic t_events();
      logic [7:0] v;
      wr(IDX_ST, 8'h0F);
      rd(IDX_ST, v); check("R3 clear all", v, 8'h00);
      pulse(0); rd(IDX_ST, v); check("R2 underflow bit0", v, 8'h01);
      pulse(1); rd(IDX_ST, v); check("R2 overflow bit1", v, 8'h03);
      pulse(2); rd(IDX_ST, v); check("R2 runlen bit2", v, 8'h07);
      repeat (3) @(negedge clk);
      rd(IDX_ST, v); check("R2 sticky", v, 8'h07);
   endtask

   task automatic t_clear();
      logic [7:0] v;
      wr(IDX_ST, 8'h02); rd(IDX_ST, v); check("R3 w1c one bit", v, 8'h05);
      wr(IDX_ST, 8'h00); rd(IDX_ST, v); check("R3 write zero no effect", v, 8'h05);
      wr(IDX_ST, 8'h0F); rd(IDX_ST, v); check("R3 clear rest", v, 8'h00);
   endtask

   task automatic t_collision();
      logic [7:0] v;
      @(negedge clk);
      ev_txovf = 1'b1; cfg_addr = IDX_ST; cfg_wdata = 8'h02; cfg_wr = 1'b1;
      @(negedge clk);
      ev_txovf = 1'b0; cfg_wr = 1'b0;
      rd(IDX_ST, v); check("R4 event beats clear", v, 8'h02);
      wr(IDX_ST, 8'h0F);
   endtask

   task automatic t_mask();
      logic [7:0] v;
      wr(IDX_MK, 8'hFF); rd(IDX_MK, v); check("R5 unmask low nibble", v, 8'h0F);
      check("R6 no status no summary", {7'b0, more_irq}, 8'h00);
      pulse(0);
      #1 check("R6 summary on", {7'b0, more_irq}, 8'h01);
      wr(IDX_MK, 8'h0E); #1 check("R6 masked off", {7'b0, more_irq}, 8'h00);
      rd(IDX_MK, v); check("R5 unmask readback", v, 8'h0E);
      wr(IDX_ST, 8'hF0); rd(IDX_ST, v); check("R7 reserved write ignored", v, 8'h01);
      rd(8'h20, v); check("R7 other index reads zero", v, 8'h00);
      wr(IDX_ST, 8'h0F); wr(IDX_MK, 8'h00);
   endtask

   task automatic pin_to(input logic lvl, input int edges);
      @(negedge clk);
      pin_in = lvl;
      repeat (edges) @(negedge clk);
   endtask

   task automatic t_pin();
      logic [7:0] v;
      pin_sel = 2'b00;
      pin_to(1'b1, 5); rd(IDX_ST, v); check("R8 off rise", v, 8'h00);
      pin_to(1'b0, 5); rd(IDX_ST, v); check("R8 off fall", v, 8'h00);
      pin_sel = 2'b01;
      pin_to(1'b1, 2); #1 check("R12 not after two edges", cfg_rd_data, 8'h00);
      @(negedge clk); #1 check("R12 set after third edge", cfg_rd_data, 8'h08);
      wr(IDX_ST, 8'h08);
      pin_to(1'b0, 5); rd(IDX_ST, v); check("R9 rising ignores fall", v, 8'h00);
      pin_sel = 2'b10;
      pin_to(1'b1, 5); rd(IDX_ST, v); check("R10 falling ignores rise", v, 8'h00);
      pin_to(1'b0, 5); rd(IDX_ST, v); check("R10 fall sets", v, 8'h08);
      wr(IDX_ST, 8'h08);
      pin_sel = 2'b11;
      pin_to(1'b1, 5); rd(IDX_ST, v); check("R11 both rise", v, 8'h08);
      wr(IDX_ST, 8'h08);
      pin_to(1'b0, 5); rd(IDX_ST, v); check("R11 both fall", v, 8'h08);
      wr(IDX_ST, 8'h08);
      pin_sel = 2'b01;
      pin_to(1'b1, 5); rd(IDX_ST, v); check("R9 rise sets", v, 8'h08);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_events();
      t_clear();
      t_collision();
      t_mask();
      t_pin();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule